// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter with Idle Parking

This block decides which of up to eight master ports owns one slave port of a multi-master crossbar. Every cycle it looks at the masters' request lines and the owner's transfer-complete signal. It drives a one-hot grant vector together with the binary index of the owner and a flag that says whether any master owns the port at all. Ownership changes only at transfer boundaries. Between them, the port stays with the master that won it.

When nobody requests, the port is parked. Three parking policies exist: park on a configured master, park on whichever master owned the port last, or park on no master at all. In the last case every owner output is driven to a fixed safe value, and a requester pays one extra cycle. A parked master that starts requesting keeps the port at once, with no added latency.

A small write-only control interface selects fixed or rotating priority, the parking policy and the park target. A sticky lock bit freezes these settings until reset and turns every later write into an error response. All pins are plain level signals. None of them is a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `xbar_slv_arb`

## Requirements
- R1: After reset the port uses fixed priority, park policy "fixed target" and target master 0, and it is unlocked. It is parked on master 0 (`grant_o`=0x01, `owner_idx_o`=0, `owner_vld_o`=1), `cfg_err_o` is 0, and the rotating pointer holds master 0.
- R2: With the priority bit at 0, the lowest-numbered requesting master wins each arbitration.
- R3: With the priority bit at 1, the search starts at the master just above the last granted one and wraps from 7 to 0.
- R4: An owner in transfer keeps the grant, even if its request drops, until `xfer_done_i` is high at a clock edge. That edge arbitrates among the current requests, and the new owner is visible on the next cycle.
- R5: On an idle port, a parked master that requests keeps its grant without a gap, ahead of any priority order. Any other requester is granted on the edge where its request is first seen.
- R6: Park policy code 00 parks the idle port on the master given by the target field.
- R7: Park policy code 01 parks the idle port on the master that last owned it.
- R8: Park policy code 10 leaves an idle port unowned (`grant_o`=0, `owner_idx_o`=0, `owner_vld_o`=0). A requester is therefore always granted one cycle after asserting its request.
- R9: The request of master 4 is ignored. That master is never granted.
- R10: A write whose policy code is 11 leaves the policy unchanged. A write whose target is 4 leaves the target unchanged. The other fields of such a write still take effect.
- R11: Setting the lock bit applies the other fields of the same write. Once set, the lock stays set until reset.
- R12: While locked, a write changes nothing, and `cfg_err_o` is high for exactly the cycle after the write. Otherwise `cfg_err_o` is 0.
- R13: The fields of `cfg_wdata_i` are: bit 0 for priority (1 = rotating), bits 2:1 for the park policy code, bits 5:3 for the park target, and bit 15 for lock. All other bits are ignored. Settings take effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request line of each master |
| xfer_done_i | input | 1 | Current owner's transfer completes this cycle |
| cfg_wr_i | input | 1 | Control write strobe |
| cfg_wdata_i | input | 16 | Control write data |
| cfg_err_o | output | 1 | Error response to a write rejected by the lock |
| grant_o | output | 8 | One-hot grant, all zero when unowned |
| owner_idx_o | output | 3 | Index of the owning or parked master |
| owner_vld_o | output | 1 | A master owns or is parked on the port |

## Verification
The bench checks that the rotating search wraps from master 7 back to 0 and skips master 4. A design with an off-by-one pointer would grant the previous owner again or wrongly grant 7. It checks that a parked master keeps its grant when it starts requesting while a higher-priority master also requests. A design that re-arbitrates here would cut a live owner off for a cycle. Each park policy is checked after a real ownership change, and writes with reserved codes are checked to leave the old setting, so a decode that accepts them shows up as the wrong park target. After the lock is set, the bench writes a config that would unlock or re-park the port and checks that the grant does not move, that the error pulse lasts exactly one cycle, and that only a reset reopens writes.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

  typedef enum logic [1:0] {
    PARK_FIXED = 2'b00,
    PARK_LAST  = 2'b01,
    PARK_NONE  = 2'b10,
    PARK_RSVD  = 2'b11
  } park_pol_e;

  // field positions inside the control write word
  localparam int CFG_DATA_W  = 16;
  localparam int CFG_RR_BIT  = 0;
  localparam int CFG_POL_LSB = 1;
  localparam int CFG_TGT_LSB = 3;
  localparam int CFG_LOCK_BIT = 15;

endpackage

// File: rtl/xbar_arb_cfg.sv
module xbar_arb_cfg
  import xbar_arb_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int RSVD_IDX = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [CFG_DATA_W-1:0] wdata,
  output logic                  rr,
  output park_pol_e             pol,
  output logic [IDX_W-1:0]      tgt,
  output logic                  lock,
  output logic                  err
);

  logic [1:0]       pol_raw;
  logic [IDX_W-1:0] tgt_raw;

  assign pol_raw = wdata[CFG_POL_LSB +: 2];
  assign tgt_raw = wdata[CFG_TGT_LSB +: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr   <= 1'b0;
      pol  <= PARK_FIXED;
      tgt  <= '0;
      lock <= 1'b0;
      err  <= 1'b0;
    end else begin
      err <= wr && lock;
      if (wr && !lock) begin
        rr   <= wdata[CFG_RR_BIT];
        lock <= wdata[CFG_LOCK_BIT];
        if (pol_raw != PARK_RSVD) pol <= park_pol_e'(pol_raw);
        if (tgt_raw != IDX_W'(RSVD_IDX)) tgt <= tgt_raw;
      end
    end
  end

endmodule

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick #(
  parameter int NUM_M = 8,
  parameter int IDX_W = 3
) (
  input  logic [NUM_M-1:0] req,
  input  logic             rr,
  input  logic [IDX_W-1:0] last,
  output logic             hit,
  output logic [IDX_W-1:0] win
);

  always_comb begin
    int base;
    int idx;
    hit  = 1'b0;
    win  = '0;
    base = rr ? int'(last) + 1 : 0;
    for (int i = 0; i < NUM_M; i++) begin
      idx = (base + i) % NUM_M;
      if (!hit && req[idx]) begin
        hit = 1'b1;
        win = IDX_W'(idx);
      end
    end
  end

endmodule

// File: rtl/xbar_slv_arb.sv
module xbar_slv_arb
  import xbar_arb_pkg::*;
#(
  parameter int NUM_M    = 8,
  parameter int RSVD_IDX = 4,
  parameter int IDX_W    = $clog2(NUM_M)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_M-1:0]      req_i,
  input  logic                  xfer_done_i,
  input  logic                  cfg_wr_i,
  input  logic [CFG_DATA_W-1:0] cfg_wdata_i,
  output logic                  cfg_err_o,
  output logic [NUM_M-1:0]      grant_o,
  output logic [IDX_W-1:0]      owner_idx_o,
  output logic                  owner_vld_o
);

  localparam logic [NUM_M-1:0] REQ_MASK = ~(NUM_M'(1) << RSVD_IDX);

  logic             cfg_rr;
  park_pol_e        cfg_pol;
  logic [IDX_W-1:0] cfg_tgt;
  logic             cfg_lock;

  logic [NUM_M-1:0] req_m;
  logic             pick_hit;
  logic [IDX_W-1:0] pick_win;

  logic [IDX_W-1:0] own_q, own_d, last_q, last_d, park_idx;
  logic             own_vld_q, own_vld_d, busy_q, busy_d, park_vld;
  logic             parked_hit, arb_now;

  xbar_arb_cfg #(.IDX_W(IDX_W), .RSVD_IDX(RSVD_IDX)) cfg_i (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (cfg_wr_i),
    .wdata(cfg_wdata_i),
    .rr   (cfg_rr),
    .pol  (cfg_pol),
    .tgt  (cfg_tgt),
    .lock (cfg_lock),
    .err  (cfg_err_o)
  );

  assign req_m = req_i & REQ_MASK;

  xbar_arb_pick #(.NUM_M(NUM_M), .IDX_W(IDX_W)) pick_i (
    .req (req_m),
    .rr  (cfg_rr),
    .last(last_q),
    .hit (pick_hit),
    .win (pick_win)
  );

  // idle destination chosen by the parking policy
  always_comb begin
    unique case (cfg_pol)
      PARK_FIXED: begin park_vld = 1'b1; park_idx = cfg_tgt; end
      PARK_LAST:  begin park_vld = 1'b1; park_idx = last_q;  end
      default:    begin park_vld = 1'b0; park_idx = '0;      end
    endcase
  end

  assign arb_now    = !busy_q || xfer_done_i;
  assign parked_hit = !busy_q && own_vld_q && req_m[own_q];

  always_comb begin
    own_d     = own_q;
    own_vld_d = own_vld_q;
    busy_d    = busy_q;
    last_d    = last_q;
    if (arb_now) begin
      if (parked_hit) begin
        busy_d = 1'b1;
        last_d = own_q;
      end else if (pick_hit) begin
        own_d     = pick_win;
        own_vld_d = 1'b1;
        busy_d    = 1'b1;
        last_d    = pick_win;
      end else begin
        own_d     = park_idx;
        own_vld_d = park_vld;
        busy_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q     <= '0;
      own_vld_q <= 1'b1;
      busy_q    <= 1'b0;
      last_q    <= '0;
    end else begin
      own_q     <= own_d;
      own_vld_q <= own_vld_d;
      busy_q    <= busy_d;
      last_q    <= last_d;
    end
  end

  for (genvar g = 0; g < NUM_M; g++) begin : g_grant
    assign grant_o[g] = own_vld_q && (own_q == IDX_W'(g));
  end

  assign owner_idx_o = own_q;
  assign owner_vld_o = own_vld_q;

endmodule

// File: rtl/xbar_slv_arb_chk.sv
module xbar_slv_arb_chk #(
  parameter int NUM_M    = 8,
  parameter int RSVD_IDX = 4,
  parameter int IDX_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_M-1:0] req_i,
  input logic             xfer_done_i,
  input logic             cfg_wr_i,
  input logic             cfg_err_o,
  input logic [NUM_M-1:0] grant_o,
  input logic [IDX_W-1:0] owner_idx_o,
  input logic             owner_vld_o,
  input logic             busy,
  input logic             lock
);

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_done_i |=> owner_vld_o && $stable(owner_idx_o));

  // R5
  parked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && owner_vld_o && req_i[owner_idx_o] && (owner_idx_o != IDX_W'(RSVD_IDX))
    |=> owner_vld_o && $stable(owner_idx_o));

  // R9
  rsvd_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(owner_vld_o && owner_idx_o == IDX_W'(RSVD_IDX)));

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  // R12
  err_on_locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i && lock |=> cfg_err_o);

  // R12
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_i |=> !cfg_err_o);

endmodule

bind xbar_slv_arb xbar_slv_arb_chk #(
  .NUM_M(NUM_M), .RSVD_IDX(RSVD_IDX), .IDX_W(IDX_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .xfer_done_i(xfer_done_i),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_err_o  (cfg_err_o),
  .grant_o    (grant_o),
  .owner_idx_o(owner_idx_o),
  .owner_vld_o(owner_vld_o),
  .busy       (busy_q),
  .lock       (cfg_lock)
);

// File: tb/xbar_slv_arb_tb_top.sv
module xbar_slv_arb_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req_i = '0;
  logic        xfer_done_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        cfg_err_o;
  logic [7:0]  grant_o;
  logic [2:0]  owner_idx_o;
  logic        owner_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  xbar_slv_arb dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .xfer_done_i(xfer_done_i),
    .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_err_o(cfg_err_o),
    .grant_o(grant_o), .owner_idx_o(owner_idx_o), .owner_vld_o(owner_vld_o)
  );

  // {req, done, expected grant, expected valid}, default config
  localparam logic [17:0] VEC [11] = '{
    {8'h00, 1'b0, 8'h01, 1'b1},
    {8'h01, 1'b0, 8'h01, 1'b1},
    {8'h06, 1'b0, 8'h01, 1'b1},
    {8'h06, 1'b1, 8'h02, 1'b1},
    {8'h06, 1'b1, 8'h02, 1'b1},
    {8'h04, 1'b1, 8'h04, 1'b1},
    {8'h10, 1'b1, 8'h01, 1'b1},
    {8'h10, 1'b0, 8'h01, 1'b1},
    {8'h80, 1'b0, 8'h80, 1'b1},
    {8'h81, 1'b1, 8'h01, 1'b1},
    {8'h00, 1'b1, 8'h01, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic [7:0] r, input logic d);
    req_i = r;
    xfer_done_i = d;
    step();
  endtask

  task automatic wr(input logic [15:0] d, input logic exp_err, input string tag);
    req_i = '0;
    xfer_done_i = 1'b0;
    cfg_wr_i = 1'b1;
    cfg_wdata_i = d;
    step();
    cfg_wr_i = 1'b0;
    chk(tag, {31'd0, cfg_err_o}, {31'd0, exp_err});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_i = '0;
    xfer_done_i = 1'b0;
    cfg_wr_i = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 grant", {24'd0, grant_o}, 32'h01);
    chk("R1 idx", {29'd0, owner_idx_o}, 32'd0);
    chk("R1 vld", {31'd0, owner_vld_o}, 32'd1);
    chk("R1 err", {31'd0, cfg_err_o}, 32'd0);

    // R2 R4 R5 R9 table under fixed priority, park on 0
    for (int k = 0; k < 11; k++) begin
      drive(VEC[k][17:10], VEC[k][9]);
      chk($sformatf("R2/R4 vec%0d grant", k), {24'd0, grant_o}, {24'd0, VEC[k][8:1]});
      chk($sformatf("R2/R4 vec%0d vld", k), {31'd0, owner_vld_o}, {31'd0, VEC[k][0]});
    end

    // R3 rotating priority with wrap, R13 bit 0
    wr(16'h0001, 1'b0, "R13 err");
    chk("R13 old cfg still parks", {24'd0, grant_o}, 32'h01);
    drive(8'h83, 1'b0);
    chk("R5 parked 0 keeps", {24'd0, grant_o}, 32'h01);
    drive(8'h83, 1'b1);
    chk("R3 after 0 -> 1", {24'd0, grant_o}, 32'h02);
    drive(8'h83, 1'b1);
    chk("R3 after 1 -> 7", {24'd0, grant_o}, 32'h80);
    drive(8'h83, 1'b1);
    chk("R3 wrap 7 -> 0", {24'd0, grant_o}, 32'h01);
    drive(8'h18, 1'b1);
    chk("R9 skip 4, R3 pick 3", {24'd0, grant_o}, 32'h08);
    drive(8'h10, 1'b1);
    chk("R9 lone 4 ignored", {24'd0, grant_o}, 32'h01);

    // R7 park on last owner (3)
    wr(16'h0003, 1'b0, "R7 err");
    drive(8'h00, 1'b0);
    chk("R7 park last 3", {24'd0, grant_o}, 32'h08);
    drive(8'h20, 1'b0);
    chk("R5 other requester one edge", {24'd0, grant_o}, 32'h20);
    drive(8'h00, 1'b1);
    chk("R7 park last 5", {24'd0, grant_o}, 32'h20);
    drive(8'h21, 1'b0);
    chk("R5 parked 5 beats 0", {24'd0, grant_o}, 32'h20);
    drive(8'h00, 1'b1);
    chk("R7 back to park", {24'd0, grant_o}, 32'h20);

    // R6 fixed target 6
    wr(16'h0030, 1'b0, "R6 err");
    drive(8'h00, 1'b0);
    chk("R6 park target 6", {24'd0, grant_o}, 32'h40);
    chk("R6 idx", {29'd0, owner_idx_o}, 32'd6);

    // R10 reserved codes
    wr(16'h0020, 1'b0, "R10 err tgt4");
    drive(8'h00, 1'b0);
    chk("R10 target 4 rejected", {24'd0, grant_o}, 32'h40);
    wr(16'h0032, 1'b0, "R10 err pol01");
    drive(8'h00, 1'b0);
    chk("R10 setup park last", {24'd0, grant_o}, 32'h20);
    wr(16'h0036, 1'b0, "R10 err pol11");
    drive(8'h00, 1'b0);
    chk("R10 policy 11 rejected", {24'd0, grant_o}, 32'h20);

    // R8 unparked
    wr(16'h0004, 1'b0, "R8 err");
    drive(8'h00, 1'b0);
    chk("R8 idle grant", {24'd0, grant_o}, 32'h00);
    chk("R8 idle vld", {31'd0, owner_vld_o}, 32'd0);
    chk("R8 idle idx", {29'd0, owner_idx_o}, 32'd0);
    drive(8'h01, 1'b0);
    chk("R8 grant one cycle later", {24'd0, grant_o}, 32'h01);
    drive(8'h00, 1'b1);
    chk("R8 back to unowned", {31'd0, owner_vld_o}, 32'd0);

    // R11 R12 lock
    wr(16'h8000, 1'b0, "R11 lock write no err");
    drive(8'h00, 1'b0);
    chk("R11 fields applied with lock", {24'd0, grant_o}, 32'h01);
    wr(16'h0030, 1'b1, "R12 locked write err");
    drive(8'h00, 1'b0);
    chk("R12 err one cycle only", {31'd0, cfg_err_o}, 32'd0);
    chk("R12 target unchanged", {24'd0, grant_o}, 32'h01);
    wr(16'h0000, 1'b1, "R11 unlock attempt err");
    wr(16'h0034, 1'b1, "R11 still locked err");
    drive(8'h00, 1'b0);
    chk("R12 policy unchanged", {24'd0, grant_o}, 32'h01);

    // R1 R11 reset clears lock and config
    do_reset();
    chk("R1 reset grant", {24'd0, grant_o}, 32'h01);
    chk("R1 reset err", {31'd0, cfg_err_o}, 32'd0);
    wr(16'h0030, 1'b0, "R11 reset unlocks");
    drive(8'h00, 1'b0);
    chk("R11 write after reset applies", {24'd0, grant_o}, 32'h40);

    finish_run();
  end

endmodule